// File: doc/BRIEF.md
# DMA Channel Error Flag Register

This block keeps one sticky error flag for each channel of a multi-channel DMA engine (16 channels by default). The engine reports a fault on a channel by pulsing that channel's bit on an error strobe input for one clock cycle. The flag then stays set until software removes it.

Software reaches the block through a simple word-addressed register port. It can read the raw flag bitmap and program a per-channel interrupt enable mask. Flags can be cleared in two ways. A write-one-to-clear write to the flag word clears any set of flags. A write to a clear-command word removes one channel's flag by index, or removes every flag when its clear-all bit is set.

The flags are gated by the mask and ORed into one registered group error interrupt. A separate summary output ORs the raw flags and ignores the mask, so polling code can find errors without enabling any interrupt. Completion signalling of the engine does not pass through this block and is not touched by it.

Top module: `dma_err_flags`

## Requirements
- R1: After reset, the flag word and the mask word read 0, and `irq_o` and `any_err_o` are 0.
- R2: A 1 on `err_set_i[n]` at a clock edge sets flag n, which reads back at offset 0x0 from that edge on and stays set until a clear reaches it.
- R3: A write to offset 0x0 clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R4: A write to offset 0x8 with data bit 7 low clears only the flag whose channel number equals data bits [3:0].
- R5: A write to offset 0x8 with data bit 7 high clears all flags, whatever the index bits hold.
- R6: When an error strobe and any clear reach the same channel in the same cycle, the flag ends up set.
- R7: Offset 0x4 is a plain read/write enable mask with bit n for channel n. Bits above the channel count read 0. A write to an unmapped offset (0xC) changes neither the mask nor the flags.
- R8: `irq_o` is the OR of (flags AND mask), registered, so it follows any change of a flag or a mask bit one cycle later.
- R9: `any_err_o` is the OR of the raw flags in the same cycle and does not depend on the mask.
- R10: Reads of offset 0x0 return the raw flags whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| err_set_i | input | NUM_CH | Per-channel error strobes from the DMA engine |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write enable (with select) |
| bus_addr_i | input | ADDR_W | Byte address: 0x0 flags, 0x4 mask, 0x8 clear command |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the current address (combinational) |
| irq_o | output | 1 | Registered group error interrupt request |
| any_err_o | output | 1 | Summary of all raw flags |

## Verification
An incoming error strobe and a software clear can land on the same channel in the same cycle. The bench provokes this case by driving the strobe for a channel during the clock edge that carries a write-one-to-clear for that channel, a clear-by-index for it, or a clear-all. In each case the scoreboard expects the flag to read back as set, while the flags of the other channels are cleared as commanded. The one-cycle lag of the interrupt behind flag and mask changes is judged by sampling it in the cycles on both sides of the change.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

   // Word slots selected by address bits [3:2]
   typedef enum logic [1:0] {
      REG_FLAGS = 2'd0,
      REG_MASK  = 2'd1,
      REG_CLR   = 2'd2,
      REG_SPARE = 2'd3
   } dma_err_reg_e;

   // Clear-all bit inside the clear-command word
   localparam int unsigned CLR_ALL_POS = 7;

endpackage

// File: rtl/dma_err_regif.sv
module dma_err_regif
   import dma_err_pkg::*;
#(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic              bus_sel_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   input  logic [NUM_CH-1:0] flags_i,
   input  logic [NUM_CH-1:0] mask_i,
   output logic [NUM_CH-1:0] clr_vec_o,
   output logic              mask_we_o,
   output logic [NUM_CH-1:0] mask_wdata_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   logic          hi_ok;
   logic          addr_ok;
   logic          wr;
   logic          w1c_hit;
   logic          clr_hit;
   logic          clr_all;
   logic [IDX_W-1:0] clr_idx;
   dma_err_reg_e  reg_sel;
   logic          unused_wdata;

   generate
      if (ADDR_W > 4) begin : g_hi_dec
         assign hi_ok = ~|bus_addr_i[ADDR_W-1:4];
      end else begin : g_hi_none
         assign hi_ok = 1'b1;
      end
   endgenerate

   assign addr_ok = hi_ok & (bus_addr_i[1:0] == 2'b00);
   assign reg_sel = dma_err_reg_e'(bus_addr_i[3:2]);
   assign wr      = bus_sel_i & bus_we_i & addr_ok;
   assign w1c_hit = wr & (reg_sel == REG_FLAGS);
   assign clr_hit = wr & (reg_sel == REG_CLR);
   assign clr_all = clr_hit & bus_wdata_i[CLR_ALL_POS];
   assign clr_idx = bus_wdata_i[IDX_W-1:0];

   assign mask_we_o    = wr & (reg_sel == REG_MASK);
   assign mask_wdata_o = bus_wdata_i[NUM_CH-1:0];

   // Per-channel clear request from both clear paths
   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_clr
         logic idx_match;
         assign idx_match     = clr_hit & ~clr_all & (clr_idx == IDX_W'(ch));
         assign clr_vec_o[ch] = (w1c_hit & bus_wdata_i[ch]) | clr_all | idx_match;
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      if (addr_ok) begin
         case (reg_sel)
            REG_FLAGS: rdata_o[NUM_CH-1:0] = flags_i;
            REG_MASK:  rdata_o[NUM_CH-1:0] = mask_i;
            default:   rdata_o = '0;
         endcase
      end
   end

   assign unused_wdata = ^bus_wdata_i;

endmodule

// File: rtl/dma_err_flag_bank.sv
module dma_err_flag_bank #(
   parameter int unsigned NUM_CH = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_CH-1:0] set_i,
   input  logic [NUM_CH-1:0] clr_i,
   output logic [NUM_CH-1:0] flags_o
);
   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cell
         // set has priority so no fault report is lost
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)          flags_o[ch] <= 1'b0;
            else if (set_i[ch])   flags_o[ch] <= 1'b1;
            else if (clr_i[ch])   flags_o[ch] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/dma_err_irq.sv
module dma_err_irq #(
   parameter int unsigned NUM_CH   = 16,
   parameter bit          IRQ_PIPE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_CH-1:0] flags_i,
   input  logic              mask_we_i,
   input  logic [NUM_CH-1:0] mask_wdata_i,
   output logic [NUM_CH-1:0] mask_o,
   output logic              irq_o,
   output logic              any_o
);
   logic irq_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mask_o <= '0;
      else if (mask_we_i) mask_o <= mask_wdata_i;
   end

   assign irq_d = |(flags_i & mask_o);
   assign any_o = |flags_i;

   generate
      if (IRQ_PIPE) begin : g_irq_reg
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) irq_o <= 1'b0;
            else         irq_o <= irq_d;
         end
      end else begin : g_irq_comb
         assign irq_o = irq_d;
      end
   endgenerate
endmodule

// File: rtl/dma_err_flags.sv
module dma_err_flags
   import dma_err_pkg::*;
#(
   parameter int unsigned NUM_CH   = 16,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 32,
   parameter bit          IRQ_PIPE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_CH-1:0] err_set_i,
   input  logic              bus_sel_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o,
   output logic              any_err_o
);
   localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   generate
      if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
         $error("NUM_CH must lie between 1 and DATA_W");
      end
      if (DATA_W <= CLR_ALL_POS) begin : g_bad_dw
         $error("DATA_W too narrow for the clear-all bit");
      end
      if (IDX_W > CLR_ALL_POS) begin : g_bad_idx
         $error("channel index overlaps the clear-all bit");
      end
      if (ADDR_W < 4) begin : g_bad_aw
         $error("ADDR_W must be at least 4");
      end
   endgenerate

   logic [NUM_CH-1:0] flags_q;
   logic [NUM_CH-1:0] mask_q;
   logic [NUM_CH-1:0] clr_vec;
   logic              mask_we;
   logic [NUM_CH-1:0] mask_wdata;

   dma_err_regif #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regif (
      .bus_sel_i    (bus_sel_i),
      .bus_we_i     (bus_we_i),
      .bus_addr_i   (bus_addr_i),
      .bus_wdata_i  (bus_wdata_i),
      .flags_i      (flags_q),
      .mask_i       (mask_q),
      .clr_vec_o    (clr_vec),
      .mask_we_o    (mask_we),
      .mask_wdata_o (mask_wdata),
      .rdata_o      (bus_rdata_o)
   );

   dma_err_flag_bank #(
      .NUM_CH (NUM_CH)
   ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (err_set_i),
      .clr_i   (clr_vec),
      .flags_o (flags_q)
   );

   dma_err_irq #(
      .NUM_CH   (NUM_CH),
      .IRQ_PIPE (IRQ_PIPE)
   ) u_irq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .flags_i      (flags_q),
      .mask_we_i    (mask_we),
      .mask_wdata_i (mask_wdata),
      .mask_o       (mask_q),
      .irq_o        (irq_o),
      .any_o        (any_err_o)
   );

endmodule

// File: rtl/dma_err_flags_chk.sv
module dma_err_flags_chk #(
   parameter int unsigned NUM_CH   = 16,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 32,
   parameter bit          IRQ_PIPE = 1'b1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [NUM_CH-1:0] err_set_i,
   input logic              bus_sel_i,
   input logic              bus_we_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [DATA_W-1:0] bus_wdata_i,
   input logic [NUM_CH-1:0] flags_i,
   input logic [NUM_CH-1:0] mask_i,
   input logic              irq_o
);
   localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   logic wr, wr_flags, wr_mask, wr_clr, quiet;
   assign wr       = bus_sel_i & bus_we_i;
   assign wr_flags = wr & (bus_addr_i == ADDR_W'(0));
   assign wr_mask  = wr & (bus_addr_i == ADDR_W'(4));
   assign wr_clr   = wr & (bus_addr_i == ADDR_W'(8));
   assign quiet    = (err_set_i == '0);

   // R2
   sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_flags || wr_clr) |=> (($past(flags_i) & ~flags_i) == '0));

   // R3
   w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_flags && quiet) |=> flags_i == ($past(flags_i) & ~$past(bus_wdata_i[NUM_CH-1:0])));

   // R4
   idx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_clr && !bus_wdata_i[7] && quiet) |=>
         flags_i == ($past(flags_i) & ~(NUM_CH'(1) << $past(bus_wdata_i[IDX_W-1:0]))));

   // R5
   clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_clr && bus_wdata_i[7] && quiet) |=> flags_i == '0);

   // R6
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !quiet |=> ((flags_i & $past(err_set_i)) == $past(err_set_i)));

   // R7
   mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_mask |=> mask_i == $past(bus_wdata_i[NUM_CH-1:0]));

   // R7
   mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_mask |=> $stable(mask_i));

   generate
      if (IRQ_PIPE) begin : g_irq_chk
         // R8
         irq_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rst_ni) |-> irq_o == |$past(flags_i & mask_i));
      end
   endgenerate

endmodule

bind dma_err_flags dma_err_flags_chk #(
   .NUM_CH   (NUM_CH),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .IRQ_PIPE (IRQ_PIPE)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .err_set_i   (err_set_i),
   .bus_sel_i   (bus_sel_i),
   .bus_we_i    (bus_we_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .flags_i     (flags_q),
   .mask_i      (mask_q),
   .irq_o       (irq_o)
);

// File: tb/dma_err_flags_tb.sv
`timescale 1ns/1ps
module dma_err_flags_tb;
   localparam int NCH = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NCH-1:0]  err = '0;
   logic            sel = 1'b0;
   logic            we = 1'b0;
   logic [3:0]      addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic            irq;
   logic            any_err;

   always #10 clk = ~clk;

   dma_err_flags u_dut (
      .clk_i(clk), .rst_ni(rst_n), .err_set_i(err),
      .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .irq_o(irq), .any_err_o(any_err)
   );

   // kind: 0 read data, 1 interrupt, 2 summary
   typedef struct {
      int          req;
      int          kind;
      logic [31:0] exp;
   } sb_item_t;

   sb_item_t sb_q[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // monitor: compares queued expectations away from the active edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         sb_item_t it;
         logic [31:0] act;
         it = sb_q.pop_front();
         case (it.kind)
            0:       act = rdata;
            1:       act = {31'd0, irq};
            default: act = {31'd0, any_err};
         endcase
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL R%0d kind %0d: actual %h expected %h", it.req, it.kind, act, it.exp);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_out(input int req, input int kind, input logic [31:0] exp);
      sb_item_t it;
      it.req = req; it.kind = kind; it.exp = exp;
      sb_q.push_back(it);
      @(negedge clk);
      #1;
   endtask

   task automatic expect_rd(input int req, input logic [3:0] a, input logic [31:0] exp);
      addr = a;
      expect_out(req, 0, exp);
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic [NCH-1:0] e);
      @(posedge clk);
      #1;
      sel = 1'b1; we = 1'b1; addr = a; wdata = d; err = e;
      step();
      sel = 1'b0; we = 1'b0; err = '0; wdata = '0;
   endtask

   task automatic pulse(input logic [NCH-1:0] e);
      err = e;
      step();
      err = '0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      expect_rd(1, 4'h0, 32'h0);
      expect_rd(1, 4'h4, 32'h0);
      expect_out(1, 1, 32'h0);
      expect_out(1, 2, 32'h0);

      // R2 set and hold; R9 summary with mask clear
      step();
      pulse(16'h1008);
      expect_rd(2, 4'h0, 32'h1008);
      expect_out(9, 2, 32'h1);
      expect_rd(2, 4'h0, 32'h1008);      // R2 sticky
      expect_out(8, 1, 32'h0);            // R8 mask zero gates irq

      // R7 mask write, upper bits dropped; R8 one-cycle lag
      bus_wr(4'h4, 32'hFFFF_0008, '0);
      expect_out(8, 1, 32'h0);
      expect_out(8, 1, 32'h1);
      expect_rd(7, 4'h4, 32'h0000_0008);
      expect_rd(10, 4'h0, 32'h1008);      // R10 raw read

      // R3 write-one-to-clear; R8 lag on falling side
      bus_wr(4'h0, 32'h0000_0008, '0);
      expect_out(8, 1, 32'h1);
      expect_out(8, 1, 32'h0);
      expect_rd(3, 4'h0, 32'h1000);

      // R4 clear by index
      bus_wr(4'h8, 32'd12, '0);
      expect_rd(4, 4'h0, 32'h0);
      expect_out(9, 2, 32'h0);
      pulse(16'hA5A5);
      bus_wr(4'h8, 32'd5, '0);
      expect_rd(4, 4'h0, 32'hA585);

      // R5 clear-all with index bits also set
      bus_wr(4'h8, 32'h0000_0083, '0);
      expect_rd(5, 4'h0, 32'h0);

      // R6 collisions on each clear path
      bus_wr(4'h0, 32'h0000_0081, 16'h0080);
      expect_rd(6, 4'h0, 32'h0080);
      bus_wr(4'h8, 32'd7, 16'h0001);
      expect_rd(6, 4'h0, 32'h0001);
      bus_wr(4'h8, 32'h0000_0080, 16'h0100);
      expect_rd(6, 4'h0, 32'h0100);

      // R9 summary ignores mask while irq stays low
      expect_out(9, 2, 32'h1);
      expect_out(8, 1, 32'h0);
      bus_wr(4'h4, 32'h0000_0100, '0);
      step();
      expect_out(8, 1, 32'h1);

      // R7 unmapped write has no effect
      bus_wr(4'hC, 32'hFFFF_FFFF, '0);
      expect_rd(7, 4'h4, 32'h0000_0100);
      expect_rd(7, 4'h0, 32'h0100);

      done = 1'b1;
      step();
      summary();
   end
endmodule